// File: doc/BRIEF.md
# Overlapping Instruction Sequence Detector

This block observes the instruction word offered to a decode stage and flags every time a programmed run of consecutive instructions goes past. Typical runs are a function entry (call, save the frame pointer, copy the stack pointer into the frame pointer) and a function exit (copy the frame pointer back, restore it, return). A word is looked at only in a cycle where the decode-valid qualifier is high, so steps are counted in decode events rather than in clocks.

Every step of every sequence holds a value and a mask. Only the instruction bits where the mask is 1 take part in the comparison, so operand fields can be ignored. Each step keeps its own progress flag, which gives two properties. An occurrence may begin while an earlier one is still in progress, and every completion is reported. A word that satisfies several steps at once also advances all of them. Each sequence drives a one-clock match pulse and a saturating hit counter. A simple select-and-read port returns the value of any one counter.

Top module: `isd_seq_detector`

## Requirements
- R1: While `rst_n` is low at a clock edge, every progress flag, every match pulse and every hit counter is cleared. A partial run that was started before the reset does not finish afterwards.
- R2: A cycle with `dec_valid` low neither advances nor breaks any partial run, whatever `instr` holds. Steps separated by such cycles still count as back-to-back.
- R3: A step matches when `instr` equals the step value in every bit position where the step mask is 1. Bits where the mask is 0 are ignored.
- R4: A sequence completes only when its steps match on consecutive decode events, in order. A decode whose word fails step k ends only the runs that needed step k. The same word may still start a new run at step 0.
- R5: Occurrences that overlap are all reported. A word that satisfies several steps advances each of them in the same decode event.
- R6: `match_o[s]` is high for exactly the one clock that follows the edge at which the final step of sequence s was decoded. It is high again only for a further completion.
- R7: Each completion raises that sequence's counter by one. The counter holds at 2^CNT_W-1 instead of wrapping, and it never decreases except through a clear.
- R8: A `cnt_clear` cycle zeroes every counter and leaves all progress flags unchanged. If a completion falls in the same cycle as the clear, the counter of that sequence becomes 1.
- R9: `stat_cnt` shows, without delay, the counter of the sequence selected by `stat_sel`. A select value of NUM_SEQ or more reads as 0.
- R10: The default patterns are listed below. "Opcode" means bits 31:24, and "fp" means bits 31:16 equal to 16'hA40B.
  - Sequence 0: opcode C1, then fp, then opcode 5E.
  - Sequence 1: opcode 5F, then opcode B4, then opcode B7.
  - Sequence 2: fp three times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decode-event qualifier; `instr` is sampled only when high |
| instr | input | WIDTH | Instruction word under decode |
| cnt_clear | input | 1 | Zeroes all hit counters |
| stat_sel | input | SEL_W | Selects the counter shown on `stat_cnt` |
| stat_cnt | output | CNT_W | Value of the selected hit counter |
| match_o | output | NUM_SEQ | One-clock completion pulse per sequence |

## Verification
Two functions can fall in the same cycle. A counter clear can coincide with a completion that increments that counter, and one decoded word can satisfy several steps of the same sequence at once. The first case is provoked by asserting `cnt_clear` on the very decode event that finishes a triple frame-pointer push. It is judged by a counter that reads 1 and a match pulse that still appears. The second case is provoked by a run of five identical pushes. Each of the third, fourth and fifth words must raise the pulse, and the counter must read 3 at the end.

// File: rtl/isd_pkg.sv
// Package isd_pkg
// Shared helpers for the instruction sequence detector.
// Assumes nothing beyond plain vectors of a common width.
package isd_pkg;

    // Wildcard equality: the mask bits at 1 are compared, the rest are ignored.
    function automatic logic wild_eq(input logic [63:0] word,
                                     input logic [63:0] value,
                                     input logic [63:0] mask);
        return ((word ^ value) & mask) == 64'd0;
    endfunction

    // Width of a select for n items, never below one bit.
    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/isd_step_compare.sv
// Module isd_step_compare
// Combinational masked comparison of one instruction word against one step.
// Assumes WIDTH <= 64; the mask bits at 1 take part in the comparison.
module isd_step_compare
    import isd_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] word,
    input  logic [WIDTH-1:0] value,
    input  logic [WIDTH-1:0] mask,
    output logic             hit
);

    // Zero-extend to the helper width and compare under the mask.
    always_comb begin
        hit = wild_eq(64'(word), 64'(value), 64'(mask));
    end

endmodule

// File: rtl/isd_track.sv
// Module isd_track
// Per-sequence progress vector. Bit k is set when steps 0..k matched on the
// last k+1 decode events. Completion is flagged combinationally (fire) and
// as a registered one-clock pulse (match_q).
// Assumes step_hit is valid only together with dec_valid; STEPS is 1 to 8.
module isd_track #(
    parameter int STEPS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [STEPS-1:0] step_hit,
    output logic             fire,
    output logic             match_q
);

    generate
        if (STEPS == 1) begin : g_single
            // A one-step sequence completes on any matching decode.
            always_comb begin
                fire = dec_valid && step_hit[0];
            end
        end else begin : g_multi
            logic [STEPS-2:0] prog;
            logic [STEPS-2:0] prog_nxt;

            // Next progress: step 0 starts alone, later steps need their predecessor.
            always_comb begin
                prog_nxt[0] = step_hit[0];
                for (int k = 1; k < STEPS - 1; k++) begin
                    prog_nxt[k] = step_hit[k] && prog[k-1];
                end
            end

            // Completion: the final step matches right after the last partial flag.
            always_comb begin
                fire = dec_valid && step_hit[STEPS-1] && prog[STEPS-2];
            end

            // Progress register, advanced only on decode events.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prog <= '0;
                end else if (dec_valid) begin
                    prog <= prog_nxt;
                end
            end

            // R2: progress is frozen while no decode event occurs.
            assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !dec_valid |=> $stable(prog));

            for (genvar k = 1; k < STEPS - 1; k++) begin : g_chain_chk
                // R4: a later flag only sets when its predecessor was set before.
                assert_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
                    (dec_valid && step_hit[k] && !prog[k]) |=> $past(prog[k-1]) == prog[k]);
            end
        end
    endgenerate

    // Registered completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
        end else begin
            match_q <= fire;
        end
    end

    // R6: a pulse is always caused by a decode event one clock earlier.
    assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match_q |-> $past(dec_valid));

    // R2: no pulse follows a cycle without a decode event.
    assert_no_pulse_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |=> !match_q);

endmodule

// File: rtl/isd_hit_counter.sv
// Module isd_hit_counter
// Saturating completion counter with a synchronous clear. A completion in
// the same cycle as a clear leaves the counter at one.
// Assumes inc is a single-cycle qualifier.
module isd_hit_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count completions, clear on request, hold at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= inc ? CNT_W'(1) : '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R7: the counter never wraps once it is full.
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);

    // R7: without a clear the counter never goes down.
    assert_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt >= $past(cnt));

    // R8: a clear leaves at most the completion of the same cycle.
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt <= CNT_W'(1));

endmodule

// File: rtl/isd_seq_detector.sv
// Module isd_seq_detector
// Top level: NUM_SEQ independent sequence trackers of STEPS masked steps
// each, with per-sequence one-clock match pulses, saturating hit counters
// and a select-and-read status port.
// Assumes the pattern vectors are packed as index (s*STEPS+k)*WIDTH.
module isd_seq_detector
    import isd_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int STEPS   = 3,
    parameter int NUM_SEQ = 3,
    parameter int CNT_W   = 4,
    parameter int SEL_W   = sel_width(NUM_SEQ),
    parameter logic [NUM_SEQ*STEPS*WIDTH-1:0] PAT_VALUE = {
        32'hA40B_0000, 32'hA40B_0000, 32'hA40B_0000,
        32'hB700_0000, 32'hB400_0000, 32'h5F00_0000,
        32'h5E00_0000, 32'hA40B_0000, 32'hC100_0000},
    parameter logic [NUM_SEQ*STEPS*WIDTH-1:0] PAT_MASK = {
        32'hFFFF_0000, 32'hFFFF_0000, 32'hFFFF_0000,
        32'hFF00_0000, 32'hFF00_0000, 32'hFF00_0000,
        32'hFF00_0000, 32'hFFFF_0000, 32'hFF00_0000}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dec_valid,
    input  logic [WIDTH-1:0]   instr,
    input  logic               cnt_clear,
    input  logic [SEL_W-1:0]   stat_sel,
    output logic [CNT_W-1:0]   stat_cnt,
    output logic [NUM_SEQ-1:0] match_o
);

    logic [CNT_W-1:0]   cnt_arr [NUM_SEQ];
    logic [NUM_SEQ-1:0] fire_vec;

    generate
        for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
            logic [STEPS-1:0] step_hit;

            for (genvar k = 0; k < STEPS; k++) begin : g_step
                isd_step_compare #(.WIDTH(WIDTH)) u_cmp (
                    .word  (instr),
                    .value (PAT_VALUE[(s*STEPS+k)*WIDTH +: WIDTH]),
                    .mask  (PAT_MASK[(s*STEPS+k)*WIDTH +: WIDTH]),
                    .hit   (step_hit[k])
                );
            end

            isd_track #(.STEPS(STEPS)) u_trk (
                .clk       (clk),
                .rst_n     (rst_n),
                .dec_valid (dec_valid),
                .step_hit  (step_hit),
                .fire      (fire_vec[s]),
                .match_q   (match_o[s])
            );

            isd_hit_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (cnt_clear),
                .inc   (fire_vec[s]),
                .cnt   (cnt_arr[s])
            );

            // R6: the pulse and the counter step are driven by the same completion.
            assert_pulse_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (match_o[s] && !$past(cnt_clear)) |->
                    (cnt_arr[s] == $past(cnt_arr[s]) + CNT_W'(1)) || (cnt_arr[s] == '1));
        end
    endgenerate

    // Status read: the selected counter, or zero for an unused select.
    always_comb begin
        stat_cnt = '0;
        for (int s = 0; s < NUM_SEQ; s++) begin
            if (stat_sel == SEL_W'(s)) begin
                stat_cnt = cnt_arr[s];
            end
        end
    end

    // R1: no pulse in the cycle right after a reset.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> match_o == '0);

endmodule

// File: tb/test_isd_seq_detector.sv
module test_isd_seq_detector;

    localparam logic [31:0] OP_CALL  = 32'hC100_0000;
    localparam logic [31:0] OP_PUSHF = 32'hA40B_0000;
    localparam logic [31:0] OP_MVSF  = 32'h5E00_0000;
    localparam logic [31:0] OP_MVFS  = 32'h5F00_0000;
    localparam logic [31:0] OP_POPF  = 32'hB400_0000;
    localparam logic [31:0] OP_RET   = 32'hB700_0000;
    localparam logic [31:0] OP_OTHER = 32'h7700_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [31:0] instr = '0;
    logic        cnt_clear = 1'b0;
    logic [1:0]  stat_sel = '0;
    logic [3:0]  stat_cnt;
    logic [2:0]  match_o;

    int n_chk = 0;
    int n_bad = 0;

    isd_seq_detector i_isd_seq_detector (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_valid (dec_valid),
        .instr     (instr),
        .cnt_clear (cnt_clear),
        .stat_sel  (stat_sel),
        .stat_cnt  (stat_cnt),
        .match_o   (match_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One decode event; on return the outputs reflect it.
    task automatic dec(input logic [31:0] word);
        instr = word;
        dec_valid = 1'b1;
        @(posedge clk);
        #1;
        dec_valid = 1'b0;
    endtask

    // Non-decode cycles carrying a word that would otherwise match.
    task automatic idle(input int n, input logic [31:0] junk);
        instr = junk;
        dec_valid = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic read_cnt(input logic [1:0] sel, output logic [3:0] v);
        stat_sel = sel;
        #1;
        v = stat_cnt;
    endtask

    // Kill all partial runs and zero the counters.
    task automatic flush();
        dec(OP_OTHER);
        cnt_clear = 1'b1;
        idle(1, OP_OTHER);
        cnt_clear = 1'b0;
    endtask

    task automatic t_reset();
        logic [3:0] v;
        chk("R1 match after reset", 32'(match_o), 0);
        for (int s = 0; s < 3; s++) begin
            read_cnt(2'(s), v);
            chk("R1 counter after reset", 32'(v), 0);
        end
        dec(OP_PUSHF);
        dec(OP_PUSHF);
        rst_n = 1'b0;
        idle(1, OP_OTHER);
        rst_n = 1'b1;
        dec(OP_PUSHF);
        chk("R1 partial run dropped by reset", 32'(match_o), 0);
    endtask

    task automatic t_basic();
        logic [3:0] v;
        flush();
        dec(OP_CALL | 32'h1234);
        chk("R10 seq0 step0 no pulse", 32'(match_o), 0);
        dec(OP_PUSHF | 32'h77);
        chk("R10 seq0 step1 no pulse", 32'(match_o), 0);
        dec(OP_MVSF);
        chk("R10 seq0 complete", 32'(match_o), 32'b001);
        idle(1, OP_OTHER);
        chk("R6 pulse lasts one clock", 32'(match_o), 0);
        read_cnt(0, v);
        chk("R7 seq0 count one", 32'(v), 1);
        dec(OP_MVFS);
        dec(OP_POPF);
        dec(OP_RET);
        chk("R10 seq1 complete", 32'(match_o), 32'b010);
        read_cnt(1, v);
        chk("R7 seq1 count one", 32'(v), 1);
    endtask

    task automatic t_gaps();
        flush();
        dec(OP_CALL);
        idle(3, OP_OTHER);
        dec(OP_PUSHF);
        idle(2, OP_CALL);
        dec(OP_MVSF);
        chk("R2 idle cycles ignored", 32'(match_o), 32'b001);
    endtask

    task automatic t_kill();
        logic [3:0] v;
        flush();
        dec(OP_CALL);
        dec(OP_PUSHF);
        dec(OP_OTHER);
        dec(OP_MVSF);
        chk("R4 interrupted run no pulse", 32'(match_o), 0);
        read_cnt(0, v);
        chk("R4 interrupted run no count", 32'(v), 0);
        dec(OP_CALL);
        dec(OP_CALL);
        dec(OP_PUSHF);
        dec(OP_MVSF);
        chk("R4 restart on failing word", 32'(match_o), 32'b001);
    endtask

    task automatic t_mask();
        flush();
        dec(32'hC1FF_FFFF);
        dec(32'hA40B_FFFF);
        dec(32'h5EAB_CDEF);
        chk("R3 operand bits ignored", 32'(match_o), 32'b001);
        dec(OP_CALL);
        dec(32'hA40C_0000);
        dec(OP_MVSF);
        chk("R3 cared bit differs", 32'(match_o), 0);
    endtask

    task automatic t_overlap();
        logic [3:0] v;
        flush();
        dec(OP_PUSHF);
        chk("R5 push 1", 32'(match_o), 0);
        dec(OP_PUSHF);
        chk("R5 push 2", 32'(match_o), 0);
        for (int i = 3; i <= 5; i++) begin
            dec(OP_PUSHF);
            chk("R5 overlapping push", 32'(match_o), 32'b100);
        end
        read_cnt(2, v);
        chk("R5 overlapping count", 32'(v), 3);
    endtask

    task automatic t_sat();
        logic [3:0] v;
        flush();
        for (int i = 1; i <= 18; i++) begin
            dec(OP_PUSHF);
            if (i == 16) begin
                read_cnt(2, v);
                chk("R7 count below saturation", 32'(v), 14);
            end
        end
        read_cnt(2, v);
        chk("R7 saturates at 15", 32'(v), 15);
    endtask

    task automatic t_clear();
        logic [3:0] v;
        dec(OP_OTHER);
        dec(OP_PUSHF);
        dec(OP_PUSHF);
        cnt_clear = 1'b1;
        dec(OP_PUSHF);
        cnt_clear = 1'b0;
        chk("R8 pulse during clear", 32'(match_o), 32'b100);
        read_cnt(2, v);
        chk("R8 clear with hit gives one", 32'(v), 1);
        read_cnt(0, v);
        chk("R8 other counter cleared", 32'(v), 0);
        dec(OP_OTHER);
        dec(OP_PUSHF);
        dec(OP_PUSHF);
        cnt_clear = 1'b1;
        idle(1, OP_OTHER);
        cnt_clear = 1'b0;
        read_cnt(2, v);
        chk("R8 plain clear", 32'(v), 0);
        dec(OP_PUSHF);
        chk("R8 tracking kept across clear", 32'(match_o), 32'b100);
    endtask

    task automatic t_sel();
        logic [3:0] v;
        read_cnt(2, v);
        chk("R9 select seq2", 32'(v), 1);
        read_cnt(3, v);
        chk("R9 unused select reads 0", 32'(v), 0);
    endtask

    initial begin
        idle(3, OP_OTHER);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_gaps();
        t_kill();
        t_mask();
        t_overlap();
        t_sat();
        t_clear();
        t_sel();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule